// File: doc/BRIEF.md
# ADC Serial Output Framer

This block drives the serial output port of a converter from a single master clock. Once per word period of 64 master clocks it takes a parallel conversion result from an upstream source through a valid/ready handshake. It then shifts that result out on a true data line and a complementary data line. The data is sent most significant bit first, and the two's complement bit pattern passes through unchanged. The block also drives a bit clock at one third of the master clock rate, the inverse of that clock, and a frame-sync strobe that marks the first bit of every word.

Sixty-four is not a multiple of three. The divide-by-three phase therefore restarts at the start of every word period, which leaves 21 whole bit periods and one spare master cycle at the end. During that spare cycle the bit clock, the data and the frame sync are all low. This is also the only cycle in which a new result is accepted. If no result is offered, the previous word is sent again.

An external alignment input restarts the word timing. It lets several devices frame their words on the same master cycle. The block runs normally if this input is held low permanently.

Top module: `adc_out_framer`

## Requirements
- R1: Within every bit period of three master cycles, `bitClk` is low in the first cycle and high in the next two. The phase restarts at cycle 0 of every word period. `bitClkN` is always the inverse of `bitClk`.
- R2: When free-running, a word period is exactly 64 master cycles, so `frameSync` rises once every 64 cycles.
- R3: Bit period b (b = 0..15) carries bit 15-b of the held word, so the MSB is sent first. The two's complement bit pattern is passed through unchanged.
- R4: `sdoN` is always the inverse of `sdo`.
- R5: `frameSync` is high for exactly the three master cycles of bit period 0, which carries the MSB, and is low otherwise.
- R6: `sdo` changes only in the cycle where `bitClk` falls or stays low. It is stable across the two cycles in which `bitClk` is high.
- R7: During bit periods 16 to 20, `sdo` is 0. In the spare cycle 63, `bitClk`, `sdo` and `frameSync` are all 0.
- R8: `inReady` is high only in cycle 63. If `inValid` is high in that cycle, `inData` becomes the word sent from the next cycle 0 onward.
- R9: If no result is accepted in cycle 63, the next word period sends the previous word again.
- R10: When `syncIn` is sampled high on a master clock edge, the following cycle is cycle 0 of a new word period, and that period sends the held word.
- R11: With `syncIn` held low, the block keeps producing word periods on its own.
- R12: While `rstN` is low, the block is at cycle 0 with a held word of zero: `frameSync` is 1, and `bitClk`, `sdo` and `inReady` are 0.

Each 16-bit word occupies one word period of 64 master cycles. Cycle c of that period lies in bit period c/3, and cycle 63 is the spare cycle. Every requirement is written for the default 16-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Word timing restart |
| inData | input | 16 | Parallel conversion result, two's complement |
| inValid | input | 1 | Result offered |
| inReady | output | 1 | Result accepted in this cycle when valid |
| bitClk | output | 1 | Serial bit clock, master clock / 3 |
| bitClkN | output | 1 | Inverse of bitClk |
| sdo | output | 1 | Serial data, MSB first |
| sdoN | output | 1 | Inverse of sdo |
| frameSync | output | 1 | High during the MSB bit period |

## Verification
The assertions check, on every cycle, that the two complement pairs stay inverse and that data holds while the bit clock is high. They also check that a frame-sync pulse lasts more than one cycle, and that the spare cycle is quiet and the only one in which the block is ready. The bench scenarios are needed to show the rest. These are the exact bit order of captured words, that an old word is repeated when no result is offered, the 64-cycle spacing of free-running frames, and that a mid-word restart begins a clean frame carrying the held word.

// File: rtl/adc_out_framer_pkg.sv
package adc_out_framer_pkg;
  typedef struct packed {
    logic load;     // start of word: reload shifter
    logic capture;  // accept inData this cycle
    logic shift;    // bit boundary: advance shifter
    logic dataEn;   // current bit period carries a data bit
    logic frameEn;  // frame-sync level
    logic clkHigh;  // bit clock level
  } ctlStrobe_t;
endpackage

// File: rtl/adc_out_framer_ctrl.sv
module adc_out_framer_ctrl
  import adc_out_framer_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int WORD_CLKS = 64,
  parameter int DIV       = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       inValid,
  output logic       inReady,
  output ctlStrobe_t ctl
);
  localparam int BITS   = WORD_CLKS / DIV;
  localparam int WCW    = $clog2(WORD_CLKS);
  localparam int BCW    = $clog2(BITS + 1);
  localparam int DCW    = $clog2(DIV);
  localparam int ACTIVE = BITS * DIV;

  logic [WCW-1:0] wordCnt;
  logic [DCW-1:0] divCnt;
  logic [BCW-1:0] bitCnt;
  logic           lastCyc;
  logic           active;

  assign lastCyc = (wordCnt == WCW'(WORD_CLKS - 1));
  assign active  = (int'(wordCnt) < ACTIVE);
  assign inReady = lastCyc;

  always_comb begin
    ctl         = '0;
    ctl.load    = lastCyc || syncIn;
    ctl.capture = lastCyc && inValid;
    ctl.shift   = !ctl.load && (divCnt == DCW'(DIV - 1));
    ctl.dataEn  = active && (int'(bitCnt) < WORD_W);
    ctl.frameEn = active && (bitCnt == '0);
    ctl.clkHigh = active && (divCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else if (ctl.load) begin
      wordCnt <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
    end else begin
      wordCnt <= wordCnt + 1'b1;
      if (divCnt == DCW'(DIV - 1)) begin
        divCnt <= '0;
        bitCnt <= bitCnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  initial begin
    if (WORD_W > BITS) $error("word width exceeds bit periods per word");
  end
endmodule

// File: rtl/adc_out_framer_dp.sv
module adc_out_framer_dp
  import adc_out_framer_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [WORD_W-1:0] inData,
  output logic              sdo,
  output logic              sdoN
);
  logic [WORD_W-1:0] heldWord;
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldWord <= '0;
      shiftReg <= '0;
    end else begin
      if (ctl.capture) heldWord <= inData;
      if (ctl.load) shiftReg <= ctl.capture ? inData : heldWord;
      else if (ctl.shift) shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
    end
  end

  assign sdo  = ctl.dataEn & shiftReg[WORD_W-1];
  assign sdoN = ~sdo;
endmodule

// File: rtl/adc_out_framer.sv
module adc_out_framer
  import adc_out_framer_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int WORD_CLKS = 64,
  parameter int DIV       = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncIn,
  input  logic [WORD_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  output logic              bitClk,
  output logic              bitClkN,
  output logic              sdo,
  output logic              sdoN,
  output logic              frameSync
);
  ctlStrobe_t ctl;

  adc_out_framer_ctrl #(.WORD_W(WORD_W), .WORD_CLKS(WORD_CLKS), .DIV(DIV)) ctrl_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .inValid(inValid),
    .inReady(inReady), .ctl(ctl)
  );

  adc_out_framer_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inData(inData),
    .sdo(sdo), .sdoN(sdoN)
  );

  assign bitClk    = ctl.clkHigh;
  assign bitClkN   = ~ctl.clkHigh;
  assign frameSync = ctl.frameEn;
endmodule

// File: rtl/adc_out_framer_chk.sv
module adc_out_framer_chk (
  input logic clk,
  input logic rstN,
  input logic inReady,
  input logic bitClk,
  input logic bitClkN,
  input logic sdo,
  input logic sdoN,
  input logic frameSync
);
  p_clk_compl_r1: assert property (@(posedge clk) disable iff (!rstN)
    bitClkN == !bitClk);

  p_data_compl_r4: assert property (@(posedge clk) disable iff (!rstN)
    sdoN == !sdo);

  p_fsync_width_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameSync) |=> frameSync);

  p_data_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (bitClk && $past(bitClk)) |-> $stable(sdo));

  p_spare_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (!bitClk && !sdo && !frameSync));

  p_ready_once_r8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> !inReady);
endmodule

bind adc_out_framer adc_out_framer_chk chk_i (
  .clk(clk), .rstN(rstN), .inReady(inReady), .bitClk(bitClk),
  .bitClkN(bitClkN), .sdo(sdo), .sdoN(sdoN), .frameSync(frameSync)
);

// File: tb/adc_out_framer_tb_top.sv
module adc_out_framer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncIn = 1'b0;
  logic [W-1:0] inData = '0;
  logic inValid = 1'b0;
  logic inReady, bitClk, bitClkN, sdo, sdoN, frameSync;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_out_framer dut_i (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .inData(inData),
    .inValid(inValid), .inReady(inReady), .bitClk(bitClk),
    .bitClkN(bitClkN), .sdo(sdo), .sdoN(sdoN), .frameSync(frameSync)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at a negedge while the design is in cycle 0; checks a whole word period.
  task automatic checkFrame(input logic [W-1:0] word, input string tag);
    int bad = 0;
    for (int k = 0; k < 64; k++) begin
      int b = k / 3;
      bit act = (k < 63);
      bit eClk = act && (k % 3 != 0);
      bit eFs  = act && (b == 0);
      bit eSdo = act && (b < W) && word[W-1-b];
      bit eRdy = (k == 63);
      if (bitClk !== eClk || bitClkN !== !eClk) begin
        bad++; check(0, {"R1 ", tag}, bitClk, eClk);
      end
      if (frameSync !== eFs) begin
        bad++; check(0, {"R5 ", tag}, frameSync, eFs);
      end
      if (sdo !== eSdo) begin
        bad++; check(0, {"R3/R7 ", tag}, sdo, eSdo);
      end
      if (sdoN !== !eSdo) begin
        bad++; check(0, {"R4 ", tag}, sdoN, !eSdo);
      end
      if (inReady !== eRdy) begin
        bad++; check(0, {"R8 ", tag}, inReady, eRdy);
      end
      @(negedge clk);
    end
    if (bad == 0) check(1, tag, 0, 0);
  endtask

  task automatic doSync();
    syncIn = 1'b1;
    @(negedge clk);
    syncIn = 1'b0;
  endtask

  task automatic testReset();
    @(negedge clk);
    check(frameSync === 1'b1, "R12 fsync", frameSync, 1);
    check(bitClk === 1'b0, "R12 bitClk", bitClk, 0);
    check(sdo === 1'b0, "R12 sdo", sdo, 0);
    check(inReady === 1'b0, "R12 ready", inReady, 0);
    rstN = 1'b1;
  endtask

  task automatic testFreeRun();
    int gap = 0;
    // R11 / R2: no sync; measure spacing of frameSync rising edges
    while (!(frameSync && !bitClk && !inReady)) @(negedge clk);
    @(negedge clk); gap = 1;
    while (!(frameSync && !bitClk)) begin
      @(negedge clk); gap++;
    end
    check(gap == 64, "R2 R11 period", gap, 64);
  endtask

  task automatic testCapture();
    doSync();
    inValid = 1'b1; inData = 16'h8001;
    checkFrame(16'h0000, "R12 R10 zero word after reset");
    inValid = 1'b0; inData = 16'hFFFF;
    checkFrame(16'h8001, "R8 R3 captured");
    checkFrame(16'h8001, "R9 repeat");
    inValid = 1'b1; inData = 16'hA5C3;
    checkFrame(16'h8001, "R9 before capture");
    inValid = 1'b1; inData = 16'h7FFE;
    checkFrame(16'hA5C3, "R3 second word");
    inValid = 1'b0;
    checkFrame(16'h7FFE, "R3 negative-free max");
  endtask

  task automatic testSyncMid();
    repeat (10) @(negedge clk);
    doSync();
    checkFrame(16'h7FFE, "R10 mid-word restart");
    repeat (40) @(negedge clk);
    doSync();
    inValid = 1'b1; inData = 16'hFFFF;
    checkFrame(16'h7FFE, "R10 second restart");
    inValid = 1'b0;
    checkFrame(16'hFFFF, "R3 all ones");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFreeRun();
    testCapture();
    testSyncMid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule